// File: doc/BRIEF.md
# MAC Control Pause Frame Receive Filter

This block watches the byte stream of a received Ethernet frame and decides whether the frame is a valid IEEE 802.3 pause request. Bytes arrive one per cycle when `in_valid` is high, with `in_sof` marking the first byte of a frame, `in_eof` the last, and `in_err` flagging a receive or FCS error on any byte. Idle cycles may appear anywhere inside a frame. The block compares the destination address, the type field and the opcode as the bytes go by, and collects the two quantum bytes.

Once the last byte has arrived, the block issues a single-cycle result. It gives the quantum on `pause_quanta` and raises `pause_zero` or `pause_nonzero` according to its value. It also increments a saturating count of accepted frames. A frame is discarded when any byte carried an error flag, when priority flow control is marked as negotiated, or when the frame is too short to contain the quantum. The downstream pause timer and the interrupt logic use these outputs.

Top module: `mac_pause_rx_filter`

## Requirements
- R1: A frame whose first six bytes equal 01-80-C2-00-00-01 (first byte on the wire first) passes the address check.
- R2: A frame whose first six bytes equal `station_addr`, with bits 47:40 as the first byte, also passes the address check. Any other destination rejects the frame.
- R3: Bytes 12-13 must be 0x88, 0x08 and bytes 14-15 must be 0x00, 0x01 (byte index counted from 0 at the start byte). Any other value rejects the frame.
- R4: On acceptance, `pause_quanta` takes byte 16 as its upper half and byte 17 as its lower half. It holds that value until the next accepted frame.
- R5: A frame with `in_err` high on any of its bytes, including the last one, is rejected.
- R6: A frame is rejected when `pfc_active` is high in the cycle of its last byte.
- R7: On acceptance, `pause_zero` pulses if the quantum is 0 and `pause_nonzero` pulses otherwise. The two are never high together.
- R8: `pause_count` rises by one for each accepted frame, saturates at its all-ones value, and otherwise holds.
- R9: `pause_valid` is a one-cycle pulse in the cycle after the clock edge that takes the last byte. Frames of fewer than 18 bytes are ignored, and longer frames (padding) are accepted.
- R10: After reset, all outputs are zero.
- R11: Cycles with `in_valid` low inside a frame are skipped. Bytes arriving outside a frame (before any start byte) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Byte present this cycle |
| in_data | input | 8 | Received byte |
| in_sof | input | 1 | First byte of frame |
| in_eof | input | 1 | Last byte of frame |
| in_err | input | 1 | Error flag on this byte |
| station_addr | input | 48 | Programmable station address |
| pfc_active | input | 1 | Priority flow control negotiated |
| pause_valid | output | 1 | Accepted pause frame pulse |
| pause_zero | output | 1 | Accepted frame with zero quantum |
| pause_nonzero | output | 1 | Accepted frame with non-zero quantum |
| pause_quanta | output | 16 | Last accepted quantum |
| pause_count | output | CNT_W | Saturating count of accepted frames |

## Verification
The assertions assume that `station_addr` and the frame flags are stable and known while a byte is valid. They also assume that an error or priority flow control flag seen at the last byte has to block the result in the next cycle. The stimulus keeps every flag at zero on idle cycles. It changes inputs only on the falling edge, and it always ends a frame with `in_eof` before it starts a new one, except where it deliberately sends stray bytes with no start flag. A behavioural model gathers each frame's bytes in a queue and judges the whole frame when the last byte arrives. Its prediction is compared with every output on every clock.

// File: rtl/mac_pause_rx_filter.sv
module mac_pause_rx_filter #(
  parameter int          CNT_W     = 16,
  parameter logic [47:0] RSV_DA    = 48'h0180C2000001,
  parameter logic [15:0] CTRL_TYPE = 16'h8808,
  parameter logic [15:0] PAUSE_OP  = 16'h0001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic             in_err,
  input  logic [47:0]      station_addr,
  input  logic             pfc_active,
  output logic             pause_valid,
  output logic             pause_zero,
  output logic             pause_nonzero,
  output logic [15:0]      pause_quanta,
  output logic [CNT_W-1:0] pause_count
);
  localparam logic [4:0]       MIN_LEN = 5'd18;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [31:0]      HDR     = {CTRL_TYPE, PAUSE_OP};

  logic        in_frame, da_rsv, da_sta, hdr_ok, err_seen;
  logic [4:0]  idx;
  logic [15:0] qv;

  logic        first, live, done, accept;
  logic [4:0]  b_idx, n_idx;
  logic        n_rsv, n_sta, n_hdr, n_err;
  logic [15:0] n_q;
  logic [47:0] rsv_sh, sta_sh;
  logic [31:0] hdr_sh;

  assign first  = in_valid && in_sof;
  assign live   = in_valid && (in_frame || in_sof);
  assign b_idx  = first ? 5'd0 : idx;
  assign rsv_sh = RSV_DA << (8 * b_idx);
  assign sta_sh = station_addr << (8 * b_idx);
  assign hdr_sh = HDR << (8 * (b_idx - 5'd12));

  always_comb begin
    n_rsv = first ? 1'b1 : da_rsv;
    n_sta = first ? 1'b1 : da_sta;
    n_hdr = first ? 1'b1 : hdr_ok;
    n_err = (first ? 1'b0 : err_seen) | in_err;
    n_q   = qv;
    if (b_idx < 5'd6) begin
      n_rsv = n_rsv && (in_data == rsv_sh[47:40]);
      n_sta = n_sta && (in_data == sta_sh[47:40]);
    end
    if (b_idx >= 5'd12 && b_idx < 5'd16)
      n_hdr = n_hdr && (in_data == hdr_sh[31:24]);
    if (b_idx == 5'd16 || b_idx == 5'd17)
      n_q = {qv[7:0], in_data};
    n_idx = (b_idx == MIN_LEN) ? MIN_LEN : b_idx + 5'd1;
  end

  assign done   = live && in_eof;
  assign accept = done && (n_idx == MIN_LEN) && (n_rsv || n_sta) && n_hdr
                  && !n_err && !pfc_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      idx      <= '0;
      da_rsv   <= 1'b0;
      da_sta   <= 1'b0;
      hdr_ok   <= 1'b0;
      err_seen <= 1'b0;
      qv       <= '0;
    end else if (live) begin
      in_frame <= !in_eof;
      idx      <= n_idx;
      da_rsv   <= n_rsv;
      da_sta   <= n_sta;
      hdr_ok   <= n_hdr;
      err_seen <= n_err;
      qv       <= n_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pause_valid   <= 1'b0;
      pause_zero    <= 1'b0;
      pause_nonzero <= 1'b0;
      pause_quanta  <= '0;
      pause_count   <= '0;
    end else begin
      pause_valid   <= accept;
      pause_zero    <= accept && (n_q == 16'd0);
      pause_nonzero <= accept && (n_q != 16'd0);
      if (accept) begin
        pause_quanta <= n_q;
        if (pause_count != CNT_MAX) pause_count <= pause_count + 1'b1;
      end
    end
  end

  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(pause_zero && pause_nonzero));
  a_r7_class: assert property (@(posedge clk) disable iff (!rst_n)
    pause_valid |-> (pause_zero == (pause_quanta == 16'd0)) && (pause_zero != pause_nonzero));
  a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_valid && $past(pause_count) != CNT_MAX) |-> pause_count == $past(pause_count) + 1'b1);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pause_valid |-> $stable(pause_count));
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pause_valid |-> $stable(pause_quanta));
  a_r5_err_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_eof && in_err) |=> !pause_valid);
  a_r6_pfc_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_eof && pfc_active) |=> !pause_valid);
  a_r9_after_eof: assert property (@(posedge clk) disable iff (!rst_n)
    pause_valid |-> $past(in_valid && in_eof));
endmodule

// File: tb/mac_pause_rx_filter_tb_top.sv
module mac_pause_rx_filter_tb_top;
  localparam int CW = 4;
  localparam logic [47:0] RSV = 48'h0180C2000001;
  localparam logic [47:0] STA = 48'h02A1B2C3D4E5;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_sof = 0, in_eof = 0, in_err = 0, pfc_active = 0;
  logic [7:0] in_data = 0;
  logic pause_valid, pause_zero, pause_nonzero;
  logic [15:0] pause_quanta;
  logic [CW-1:0] pause_count;
  int checks = 0, bad = 0, pulses = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  mac_pause_rx_filter #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .in_err(in_err), .station_addr(STA),
    .pfc_active(pfc_active), .pause_valid(pause_valid), .pause_zero(pause_zero),
    .pause_nonzero(pause_nonzero), .pause_quanta(pause_quanta), .pause_count(pause_count));

  // behavioural reference model
  byte unsigned fq[$];
  bit m_in, m_err;
  logic e_valid, e_zero, e_nz;
  logic [15:0] e_q;
  int e_cnt;

  function automatic bit judge();
    logic [47:0] da; logic [15:0] ty, op;
    if (fq.size() < 18 || m_err || pfc_active) return 0;
    da = 0;
    for (int i = 0; i < 6; i++) da = {da[39:0], fq[i]};
    ty = {fq[12], fq[13]}; op = {fq[14], fq[15]};
    return (da == RSV || da == STA) && ty == 16'h8808 && op == 16'h0001;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fq = {}; m_in = 0; m_err = 0;
      e_valid = 0; e_zero = 0; e_nz = 0; e_q = 0; e_cnt = 0;
    end else begin
      e_valid = 0; e_zero = 0; e_nz = 0;
      if (in_valid) begin
        if (in_sof) begin fq = {}; m_in = 1; m_err = 0; end
        if (m_in) begin
          fq.push_back(in_data);
          m_err = m_err | in_err;
          if (in_eof) begin
            m_in = 0;
            if (judge()) begin
              e_valid = 1;
              e_q = {fq[16], fq[17]};
              e_zero = (e_q == 0); e_nz = (e_q != 0);
              if (e_cnt < (1 << CW) - 1) e_cnt++;
            end
          end
        end
      end
    end
  end

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h at %0t", req, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (!finished) begin
    chk("R9 valid", pause_valid, e_valid);
    chk("R4 quanta", pause_quanta, e_q);
    chk("R7 zero", pause_zero, e_zero);
    chk("R7 nonzero", pause_nonzero, e_nz);
    chk("R8 count", pause_count, e_cnt);
    if (pause_valid) pulses++;
  end

  function automatic logic [7:0] fbyte(logic [47:0] da, logic [15:0] ty, logic [15:0] op,
                                       logic [15:0] qv, int i);
    if (i < 6) return da[8*(5-i) +: 8];
    if (i < 12) return 8'h20 + 8'(i);
    if (i == 12) return ty[15:8];
    if (i == 13) return ty[7:0];
    if (i == 14) return op[15:8];
    if (i == 15) return op[7:0];
    if (i == 16) return qv[15:8];
    if (i == 17) return qv[7:0];
    return 8'h00;
  endfunction

  task automatic send(logic [47:0] da, logic [15:0] ty, logic [15:0] op, logic [15:0] qv,
                      int len, int err_at, int gap, bit pfc);
    for (int i = 0; i < len; i++) begin
      in_valid = 1; in_data = fbyte(da, ty, op, qv, i);
      in_sof = (i == 0); in_eof = (i == len - 1); in_err = (i == err_at);
      pfc_active = pfc && (i == len - 1);
      @(negedge clk);
      in_valid = 0; in_sof = 0; in_eof = 0; in_err = 0; pfc_active = 0;
      if (gap > 0 && i % gap == 0) @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_pulses(string req, int exp);
    chk(req, pulses, exp);
    pulses = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; $display("FAIL watchdog expired");
      finished = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 valid", pause_valid, 0);
    chk("R10 count", pause_count, 0);
    chk("R10 quanta", pause_quanta, 0);
    rst_n = 1;
    @(negedge clk); pulses = 0;
    send(RSV, 16'h8808, 16'h0001, 16'h1234, 18, -1, 0, 0);
    expect_pulses("R1 reserved da", 1);
    chk("R4 quanta value", pause_quanta, 16'h1234);
    send(STA, 16'h8808, 16'h0001, 16'h0000, 18, -1, 0, 0);
    expect_pulses("R2 station da zero quantum", 1);
    send(48'h0180C2000002, 16'h8808, 16'h0001, 16'h0055, 18, -1, 0, 0);
    expect_pulses("R2 foreign da", 0);
    chk("R4 quanta held", pause_quanta, 16'h0000);
    send(RSV, 16'h8809, 16'h0001, 16'h0055, 18, -1, 0, 0);
    expect_pulses("R3 bad type", 0);
    send(RSV, 16'h8808, 16'h0101, 16'h0055, 18, -1, 0, 0);
    expect_pulses("R3 bad opcode", 0);
    send(RSV, 16'h8808, 16'h0001, 16'h0055, 18, 3, 0, 0);
    expect_pulses("R5 early error", 0);
    send(STA, 16'h8808, 16'h0001, 16'h0055, 64, 63, 0, 0);
    expect_pulses("R5 late error", 0);
    send(RSV, 16'h8808, 16'h0001, 16'h0055, 18, -1, 0, 1);
    expect_pulses("R6 pfc active", 0);
    send(RSV, 16'h8808, 16'h0001, 16'h0055, 17, -1, 0, 0);
    expect_pulses("R9 short frame", 0);
    send(STA, 16'h8808, 16'h0001, 16'hFFFF, 64, -1, 0, 0);
    expect_pulses("R9 padded frame", 1);
    chk("R7 nonzero quantum", pause_quanta, 16'hFFFF);
    send(RSV, 16'h8808, 16'h0001, 16'h0A0B, 20, -1, 2, 0);
    expect_pulses("R11 gaps", 1);
    for (int i = 0; i < 5; i++) begin
      in_valid = 1; in_data = 8'h88; in_eof = (i == 4); @(negedge clk);
    end
    in_valid = 0; in_eof = 0;
    repeat (3) @(negedge clk);
    expect_pulses("R11 stray bytes", 0);
    for (int k = 0; k < 14; k++) send(RSV, 16'h8808, 16'h0001, 16'(k + 1), 18, -1, 0, 0);
    expect_pulses("R8 many frames", 14);
    chk("R8 saturated", pause_count, 15);
    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule